// File: doc/BRIEF.md
# Multiply-Divide Unit with Private Result Pair

This block performs integer multiply and divide for a 32-bit core. It keeps its own 64-bit result pair, made of an upper word (HI) and a lower word (LO). That pair sits outside the general register file. Software cannot name it as an operand: the only way to read it is a move request, which returns one half on the result port.

Multiplies finish in the cycle they are accepted. A multiply either overwrites the pair, adds its product to the pair, or subtracts its product from the pair. Signed and unsigned forms of each exist. A separate three-operand multiply returns only the low word of the signed product on the result port and leaves the pair alone.

Divides run as a fixed sequence of one step per cycle. While a divide runs the unit reports busy and drops its ready output. The requester must hold any new request, including a move, until ready returns. That refusal is the stall handshake.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is low, `req_ready` is high and `rsp_valid` is low.
- R2: Op 0 (signed) and op 1 (unsigned) write the 64-bit product of `opa` and `opb` into the pair, upper word to HI and lower word to LO, at the accepting clock edge.
- R3: Op 2 (signed) and op 3 (unsigned) add the 64-bit product to the HI:LO pair, wrapping modulo 2^64.
- R4: Op 4 (signed) and op 5 (unsigned) subtract the 64-bit product from the HI:LO pair, wrapping modulo 2^64.
- R5: Op 10 places the low 32 bits of the signed product on `rsp_data`, with `rsp_valid` high in the cycle after acceptance. HI and LO are unchanged.
- R6: Op 8 returns HI and op 9 returns LO on `rsp_data`, with `rsp_valid` high in the cycle after acceptance. Neither changes the pair.
- R7: Op 6 (signed) and op 7 (unsigned) divide `opa` by `opb`. `busy` is high for exactly 32 cycles after acceptance. When it falls, LO holds the quotient and HI holds the remainder.
- R8: A signed divide truncates the quotient toward zero, and the remainder takes the dividend's sign. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R9: A divide by zero still runs its 32 busy cycles, raises no error and leaves HI and LO unchanged.
- R10: While `busy` is high, `req_ready` is low. A request held during that time has no effect until it is accepted after the divide completes. The pair does not change during the divide except at its final step.
- R11: Op codes 11 to 15 are accepted and have no effect: no response and no change to the pair.
- R12: `rsp_valid` is high only in the cycle after an accepted op 8, 9 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_op | input | 4 | Operation code |
| opa | input | 32 | First operand (multiplicand / dividend) |
| opb | input | 32 | Second operand (multiplier / divisor) |
| busy | output | 1 | Divide in progress |
| rsp_valid | output | 1 | Result word valid |
| rsp_data | output | 32 | Moved half or three-operand product |

## Verification
Every cycle, the assertions check four things:
- a response appears only after an accepted request;
- move requests leave the pair untouched;
- the pair holds still while a divide is under way;
- each divide keeps `busy` high for exactly 32 cycles.

They also recompute the unsigned product after op 1. The arithmetic of the signed and accumulating forms is left to the bench: the rounding of signed divides, the wraparound of accumulation, and the behaviour on a zero divisor. So are stalled moves that must return the post-divide value, and refused requests that must not take effect early. The bench shows these through its scenarios, comparing against its reference model on every clock.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [3:0] {
        OP_MULS = 4'd0,
        OP_MULU = 4'd1,
        OP_MACS = 4'd2,
        OP_MACU = 4'd3,
        OP_MSUS = 4'd4,
        OP_MSUU = 4'd5,
        OP_DIVS = 4'd6,
        OP_DIVU = 4'd7,
        OP_RDHI = 4'd8,
        OP_RDLO = 4'd9,
        OP_MUL3 = 4'd10
    } md_op_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int W = 32
) (
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    logic [PW-1:0] a_ext, b_ext;

    always_comb begin
        a_ext = {{W{sgn & a[W-1]}}, a};
        b_ext = {{W{sgn & b[W-1]}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         fin,
    output logic         dz,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg_q;
        logic          neg_r;
        logic          dz;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0] r_sh, diff;

    always_comb begin
        st_d = st_q;
        fin  = 1'b0;
        r_sh = {st_q.rem, st_q.quo[W-1]};
        diff = r_sh - {1'b0, st_q.dvs};
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = CW'(W);
            st_d.rem   = '0;
            st_d.quo   = (sgn & a[W-1]) ? -a : a;
            st_d.dvs   = (sgn & b[W-1]) ? -b : b;
            st_d.neg_q = sgn & (a[W-1] ^ b[W-1]);
            st_d.neg_r = sgn & a[W-1];
            st_d.dz    = (b == '0);
        end else if (st_q.busy) begin
            if (!diff[W]) begin
                st_d.rem = diff[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = r_sh[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                fin       = 1'b1;
            end
        end
        quo = st_d.neg_q ? -st_d.quo : st_d.quo;
        rem = st_d.neg_r ? -st_d.rem : st_d.rem;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign dz   = st_q.dz;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [3:0]   req_op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] hilo;
        logic          rsp_valid;
        logic [W-1:0]  rsp_data;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic          accept, mul_sgn, div_sgn, div_go;
    logic          div_busy, div_fin, div_dz;
    logic [W-1:0]  div_quo, div_rem;
    logic [PW-1:0] prod;

    always_comb begin
        accept  = req_valid && !div_busy;
        mul_sgn = 1'b0;
        div_sgn = 1'b0;
        div_go  = 1'b0;
        case (req_op)
            OP_MULS, OP_MACS, OP_MSUS, OP_MUL3: mul_sgn = 1'b1;
            OP_DIVS: begin div_sgn = 1'b1; div_go = accept; end
            OP_DIVU: div_go = accept;
            default: ;
        endcase
    end

    muldiv_mul #(.W(W)) u_mul (
        .sgn(mul_sgn), .a(opa), .b(opb), .prod(prod)
    );

    muldiv_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_go), .sgn(div_sgn),
        .a(opa), .b(opb), .busy(div_busy), .fin(div_fin), .dz(div_dz),
        .quo(div_quo), .rem(div_rem)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        if (div_fin && !div_dz) st_d.hilo = {div_rem, div_quo};
        if (accept) begin
            case (req_op)
                OP_MULS, OP_MULU: st_d.hilo = prod;
                OP_MACS, OP_MACU: st_d.hilo = st_q.hilo + prod;
                OP_MSUS, OP_MSUU: st_d.hilo = st_q.hilo - prod;
                OP_MUL3: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = prod[W-1:0];
                end
                OP_RDHI: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = st_q.hilo[PW-1:W];
                end
                OP_RDLO: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = st_q.hilo[W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !div_busy;
    assign busy      = div_busy;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [3:0]     req_op,
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic           busy,
    input logic           rsp_valid,
    input logic [2*W-1:0] hilo
);
    localparam int CW = $clog2(W + 1) + 1;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + CW'(1);
        else           run_q <= '0;
    end

    AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready)); // R12
    AST_MOVE_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && (req_op == OP_RDHI || req_op == OP_RDLO))
        |-> $stable(hilo)); // R6
    AST_HOLD_WHILE_DIVIDING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(hilo)); // R10
    AST_DIV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CW'(W))); // R7
    AST_UMUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && req_op == OP_MULU)
        |-> (hilo == ({{W{1'b0}}, $past(opa)} * {{W{1'b0}}, $past(opb)}))); // R2
endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .opa(opa), .opb(opb), .busy(busy),
    .rsp_valid(rsp_valid), .hilo(st_q.hilo)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    import muldiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = 4'd0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy, rsp_valid;
    logic [31:0] rsp_data;

    always #2 clk = ~clk;

    muldiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .opa(opa), .opb(opb), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_hi, m_lo, m_rdata, p_q, p_r;
    bit          m_rvalid, p_dz;
    int          m_cnt;

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    always @(posedge clk) begin : model
        logic [63:0] uprod, sprod;
        longint      sa, sb;
        bit          acc;
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_rvalid = 0; m_rdata = '0; m_cnt = 0; p_dz = 0;
        end else begin
            acc      = req_valid && (m_cnt == 0);
            m_rvalid = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0 && !p_dz) begin m_hi = p_r; m_lo = p_q; end
            end
            if (acc) begin
                sa    = longint'($signed(opa));
                sb    = longint'($signed(opb));
                sprod = 64'(sa * sb);
                uprod = {32'b0, opa} * {32'b0, opb};
                case (req_op)
                    OP_MULS: {m_hi, m_lo} = sprod;
                    OP_MULU: {m_hi, m_lo} = uprod;
                    OP_MACS: {m_hi, m_lo} = {m_hi, m_lo} + sprod;
                    OP_MACU: {m_hi, m_lo} = {m_hi, m_lo} + uprod;
                    OP_MSUS: {m_hi, m_lo} = {m_hi, m_lo} - sprod;
                    OP_MSUU: {m_hi, m_lo} = {m_hi, m_lo} - uprod;
                    OP_MUL3: begin m_rvalid = 1; m_rdata = sprod[31:0]; end
                    OP_RDHI: begin m_rvalid = 1; m_rdata = m_hi; end
                    OP_RDLO: begin m_rvalid = 1; m_rdata = m_lo; end
                    OP_DIVS: begin
                        m_cnt = 32; p_dz = (opb == 0);
                        if (!p_dz) begin p_q = 32'(sa / sb); p_r = 32'(sa % sb); end
                    end
                    OP_DIVU: begin
                        m_cnt = 32; p_dz = (opb == 0);
                        if (!p_dz) begin p_q = opa / opb; p_r = opa % opb; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(req_ready == (m_cnt == 0), "R10 ready", 64'(req_ready), 64'(m_cnt == 0));
            chk(busy == (m_cnt != 0), "R7 busy", 64'(busy), 64'(m_cnt != 0));
            chk(rsp_valid == m_rvalid, "R12 rsp_valid", 64'(rsp_valid), 64'(m_rvalid));
            if (m_rvalid) chk(rsp_data == m_rdata, "R6 rsp_data", 64'(rsp_data), 64'(m_rdata));
        end
    end

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        req_valid = 1'b1; req_op = op; opa = a; opb = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input bit hi, output logic [31:0] v);
        issue(hi ? OP_RDHI : OP_RDLO, '0, '0);
        v = rsp_data;
    endtask

    task automatic pair(input string tag, input logic [31:0] ehi, input logic [31:0] elo);
        logic [31:0] h, l;
        rd(1'b1, h);
        chk(h == ehi, {tag, " HI"}, 64'(h), 64'(ehi));
        rd(1'b0, l);
        chk(l == elo, {tag, " LO"}, 64'(l), 64'(elo));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        int bcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !rsp_valid, "R1 idle outputs",
            {req_ready, busy, rsp_valid}, 64'b100);
        pair("R1 reset", 32'h0, 32'h0);

        issue(OP_MULU, 32'hFFFFFFFF, 32'hFFFFFFFF);
        pair("R2 unsigned mult", 32'hFFFFFFFE, 32'h00000001);
        issue(OP_MULS, 32'hFFFFFFFF, 32'd5);
        pair("R2 signed mult", 32'hFFFFFFFF, 32'hFFFFFFFB);

        issue(OP_MACS, 32'hFFFFFFFD, 32'd4);
        pair("R3 signed madd", 32'hFFFFFFFF, 32'hFFFFFFEF);
        issue(OP_MULU, 32'hFFFFFFFF, 32'hFFFFFFFF);
        issue(OP_MACU, 32'hFFFFFFFF, 32'hFFFFFFFF);
        pair("R3 unsigned madd wrap", 32'hFFFFFFFC, 32'h00000002);

        issue(OP_MULU, 32'd0, 32'd0);
        issue(OP_MSUS, 32'd2, 32'd3);
        pair("R4 signed msub", 32'hFFFFFFFF, 32'hFFFFFFFA);
        issue(OP_MSUU, 32'hFFFFFFFF, 32'd2);
        pair("R4 unsigned msub", 32'hFFFFFFFD, 32'hFFFFFFFC);

        issue(OP_MUL3, 32'hFFFFFFF9, 32'd6);
        chk(rsp_valid && rsp_data == 32'hFFFFFFD6, "R5 low product",
            64'(rsp_data), 64'hFFFFFFD6);
        pair("R5 pair untouched", 32'hFFFFFFFD, 32'hFFFFFFFC);
        pair("R6 repeated move", 32'hFFFFFFFD, 32'hFFFFFFFC);

        issue(OP_DIVU, 32'd100, 32'd7);
        bcnt = 0;
        while (busy) begin bcnt++; @(negedge clk); end
        chk(bcnt == 32, "R7 busy length", 64'(bcnt), 64'd32);
        pair("R7 unsigned divide", 32'd2, 32'd14);

        issue(OP_DIVS, 32'hFFFFFFF9, 32'd2);
        pair("R8 neg dividend (stalled move R10)", 32'hFFFFFFFF, 32'hFFFFFFFD);
        issue(OP_DIVS, 32'd7, 32'hFFFFFFFE);
        pair("R8 neg divisor", 32'd1, 32'hFFFFFFFD);
        issue(OP_DIVS, 32'h80000000, 32'hFFFFFFFF);
        pair("R8 min by minus one", 32'd0, 32'h80000000);

        issue(OP_DIVU, 32'd5, 32'd0);
        bcnt = 0;
        while (busy) begin bcnt++; @(negedge clk); end
        chk(bcnt == 32, "R9 zero divisor busy length", 64'(bcnt), 64'd32);
        pair("R9 zero divisor keeps pair", 32'd0, 32'h80000000);

        issue(OP_DIVU, 32'd9, 32'd4);
        issue(OP_MULU, 32'd3, 32'd3);
        pair("R10 held request lands after divide", 32'd0, 32'd9);

        issue(4'd12, 32'h12345678, 32'h9ABCDEF0);
        chk(!rsp_valid, "R11 no response", 64'(rsp_valid), 64'd0);
        issue(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF);
        pair("R11 unused code", 32'd0, 32'd9);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule